// File: doc/BRIEF.md
# Page Permission Fault Checker

This block takes the permission bits of a leaf page-table entry and decides whether a memory access to that page may proceed. The entry bits come from a completed page walk or a translation cache hit, and the block also receives the access kind, the current privilege level and two status controls. The first control lets supervisor code touch user data. The second lets loads read pages that are marked executable. When the access is not allowed, the block reports one of three page-fault kinds: instruction, load or store.

The decision is combinational. It is captured in a single output register that carries a valid flag and a 2-bit fault code. A result is presented one cycle after each valid request. Read-modify-write atomics are treated as stores in every case, so an atomic never produces a load fault. Supervisor instruction fetch from a user page is always refused, whatever the supervisor-access control says.

Top module: `pf_checker`

## Requirements
- R1: A fetch (access code 0) to a page with X=0 faults with fault code 1 (instruction).
- R2: A load or load-reserved (access code 1) to a page with R=0 faults with fault code 2 (load), except as allowed by R8.
- R3: A store or store-conditional (access code 2, whether it succeeds or not) and an atomic (access code 3) to a page with W=0 fault with fault code 3 (store).
- R4: An atomic never yields fault code 2; an atomic to a page with R=0 yields fault code 3.
- R5: In user mode (priv_user=1), any access to a page with U=0 faults, classified by access code.
- R6: In supervisor mode (priv_user=0), a fetch from a page with U=1 faults with code 1 regardless of sum_en.
- R7: In supervisor mode, a data access (codes 1–3) to a page with U=1 is allowed only when sum_en=1; otherwise it faults.
- R8: With mxr_en=1, a load is permitted on a page with X=1 even when R=0, as long as the entry is well formed.
- R9: An entry with V=0, or with W=1 and R=0, faults for every access code, classified by access code.
- R10: For a request with req_valid=1 at a clock edge, rsp_valid is 1 after that edge and rsp_fault holds the code (0 none, 1 instruction, 2 load, 3 store).
- R11: While rst is high, the next edge drives rsp_valid to 0 and rsp_fault to 0.
- R12: A cycle with req_valid=0 yields rsp_valid=0 and rsp_fault=0 after the edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| pte_v | input | 1 | Entry valid bit |
| pte_r | input | 1 | Entry readable bit |
| pte_w | input | 1 | Entry writable bit |
| pte_x | input | 1 | Entry executable bit |
| pte_u | input | 1 | Entry user-accessible bit |
| acc | input | 2 | Access code: 0 fetch, 1 load/LR, 2 store/SC, 3 atomic |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| sum_en | input | 1 | Supervisor may access user data pages |
| mxr_en | input | 1 | Loads may read executable pages |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 2 | Fault code: 0 none, 1 instruction, 2 load, 3 store |

## Verification
Every result appears exactly one clock edge after the request that caused it, because only the output register lies between the inputs and rsp_fault. The bench applies stimulus on the falling edge, waits for the next rising edge and samples 1 ns later, so each sample reads the register loaded from that single request. The sweep covers all 1024 combinations of entry bits, access code, mode and both controls. After every fourth combination it inserts an idle cycle with scrambled side inputs to confirm that the outputs drop to zero in that same one-edge window.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_AMO   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_INSN  = 2'd1,
        FLT_LOAD  = 2'd2,
        FLT_STORE = 2'd3
    } flt_e;

    typedef struct packed {
        logic v;
        logic r;
        logic w;
        logic x;
        logic u;
    } pte_bits_t;

    typedef struct packed {
        logic user;
        logic sum;
        logic mxr;
    } mode_ctx_t;

    typedef struct packed {
        logic valid;
        flt_e fault;
    } rsp_t;

    // Fault kind an access produces when refused; atomics map to store.
    function automatic flt_e fault_kind(input acc_e a);
        case (a)
            ACC_FETCH: fault_kind = FLT_INSN;
            ACC_LOAD:  fault_kind = FLT_LOAD;
            default:   fault_kind = FLT_STORE;
        endcase
    endfunction

endpackage

// File: rtl/pf_pte_decode.sv
module pf_pte_decode
    import pf_pkg::*;
(
    input  pte_bits_t pte,
    input  logic      mxr,
    output logic      malformed,
    output logic      load_ok,
    output logic      store_ok,
    output logic      fetch_ok
);
    always_comb begin
        malformed = !pte.v || (pte.w && !pte.r);
        load_ok   = pte.r || (mxr && pte.x);
        store_ok  = pte.w;
        fetch_ok  = pte.x;
    end
endmodule

// File: rtl/pf_rule_check.sv
module pf_rule_check
    import pf_pkg::*;
(
    input  acc_e      acc,
    input  mode_ctx_t ctx,
    input  logic      page_user,
    input  logic      malformed,
    input  logic      load_ok,
    input  logic      store_ok,
    input  logic      fetch_ok,
    output flt_e      fault
);
    logic priv_deny;
    logic kind_deny;

    always_comb begin
        if (ctx.user) begin
            priv_deny = !page_user;
        end else begin
            priv_deny = page_user && ((acc == ACC_FETCH) || !ctx.sum);
        end

        case (acc)
            ACC_FETCH: kind_deny = !fetch_ok;
            ACC_LOAD:  kind_deny = !load_ok;
            default:   kind_deny = !store_ok;
        endcase

        fault = (malformed || priv_deny || kind_deny) ? fault_kind(acc) : FLT_NONE;
    end

    // R4: an atomic never resolves to a load fault
    always_comb begin
        if (acc == ACC_AMO) a_r4_amo_kind: assert (fault != FLT_LOAD);
    end
endmodule

// File: rtl/pf_resp_reg.sv
module pf_resp_reg
    import pf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  flt_e in_fault,
    output rsp_t rsp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '{valid: 1'b0, fault: FLT_NONE};
        end else begin
            rsp.valid <= in_valid;
            rsp.fault <= in_valid ? in_fault : FLT_NONE;
        end
    end
endmodule

// File: rtl/pf_checker.sv
module pf_checker
    import pf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       pte_v,
    input  logic       pte_r,
    input  logic       pte_w,
    input  logic       pte_x,
    input  logic       pte_u,
    input  logic [1:0] acc,
    input  logic       priv_user,
    input  logic       sum_en,
    input  logic       mxr_en,
    output logic       rsp_valid,
    output logic [1:0] rsp_fault
);
    pte_bits_t pte;
    mode_ctx_t ctx;
    acc_e      acc_k;
    logic      malformed, load_ok, store_ok, fetch_ok;
    flt_e      comb_fault;
    rsp_t      rsp;

    assign pte   = '{v: pte_v, r: pte_r, w: pte_w, x: pte_x, u: pte_u};
    assign ctx   = '{user: priv_user, sum: sum_en, mxr: mxr_en};
    assign acc_k = acc_e'(acc);

    pf_pte_decode u_dec (
        .pte       (pte),
        .mxr       (ctx.mxr),
        .malformed (malformed),
        .load_ok   (load_ok),
        .store_ok  (store_ok),
        .fetch_ok  (fetch_ok)
    );

    pf_rule_check u_rule (
        .acc       (acc_k),
        .ctx       (ctx),
        .page_user (pte.u),
        .malformed (malformed),
        .load_ok   (load_ok),
        .store_ok  (store_ok),
        .fetch_ok  (fetch_ok),
        .fault     (comb_fault)
    );

    pf_resp_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_fault (comb_fault),
        .rsp      (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_fault = rsp.fault;

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_fault == 2'd0));

    a_r9_malformed_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!pte_v || (pte_w && !pte_r))) |=> (rsp_fault != 2'd0));

    a_r6_sup_fetch_user: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc == 2'd0 && !priv_user && pte_u) |=> (rsp_fault == 2'd1));

    a_r1_fetch_code: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc == 2'd0) |=> (rsp_fault == 2'd0 || rsp_fault == 2'd1));

    a_r4_amo_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc == 2'd3 && !pte_r) |=> (rsp_fault == 2'd3));
endmodule

// File: tb/pf_checker_test.sv
module pf_checker_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       pte_v, pte_r, pte_w, pte_x, pte_u;
    logic [1:0] acc;
    logic       priv_user, sum_en, mxr_en;
    logic       rsp_valid;
    logic [1:0] rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pf_checker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_x(pte_x), .pte_u(pte_u),
        .acc(acc), .priv_user(priv_user), .sum_en(sum_en), .mxr_en(mxr_en),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int expect_code(input logic [4:0] b, input int a,
                                       input logic usr, input logic sm, input logic mx);
        logic v, r, w, x, u, bad, pdeny, need;
        {v, r, w, x, u} = b;
        bad = !v || (w && !r);
        pdeny = usr ? !u : (u && (a == 0 || !sm));
        need = (a == 0) ? x : (a == 1) ? (r || (mx && x)) : w;
        if (bad || pdeny || !need) return (a >= 2) ? 3 : a + 1;
        return 0;
    endfunction

    function automatic string tag_of(input logic [4:0] b, input int a,
                                     input logic usr, input logic sm);
        logic v, r, w, x, u;
        {v, r, w, x, u} = b;
        if (!v || (w && !r)) return "R9";
        if (usr && !u) return "R5";
        if (!usr && u && a == 0) return "R6";
        if (!usr && u && !sm) return "R7";
        if (a == 3) return "R4";
        if (a == 1 && !r && x) return "R8";
        if (a == 0) return "R1";
        if (a == 1) return "R2";
        return "R3";
    endfunction

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b1;
        {pte_v, pte_r, pte_w, pte_x, pte_u} = 5'b11111;
        acc = 2'd3; priv_user = 1'b0; sum_en = 1'b0; mxr_en = 1'b0;
        @(posedge clk); #1;
        check("R11 valid", int'(rsp_valid), 0);
        check("R11 fault", int'(rsp_fault), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 1024; i++) begin
            logic [4:0] b;
            int a;
            logic usr, sm, mx;
            b   = i[4:0];
            a   = i[6:5];
            usr = i[7];
            sm  = i[8];
            mx  = i[9];
            @(negedge clk);
            req_valid = 1'b1;
            {pte_v, pte_r, pte_w, pte_x, pte_u} = b;
            acc = a[1:0]; priv_user = usr; sum_en = sm; mxr_en = mx;
            @(posedge clk); #1;
            check("R10 valid", int'(rsp_valid), 1);
            check(tag_of(b, a, usr, sm), int'(rsp_fault), expect_code(b, a, usr, sm, mx));
            if (a == 3) check("R4 never load", int'(rsp_fault == 2'd2), 0);
            if (i % 4 == 3) begin
                @(negedge clk);
                req_valid = 1'b0;
                {pte_v, pte_r, pte_w, pte_x, pte_u} = ~b;
                acc = ~a[1:0];
                @(posedge clk); #1;
                check("R12 valid", int'(rsp_valid), 0);
                check("R12 fault", int'(rsp_fault), 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule